// File: doc/BRIEF.md
# Accumulator Round-and-Clamp Readout

This block is a purely combinational unit that narrows a bank of wide per-lane accumulators into one packed 64-bit word. Each lane's accumulator is shifted right by a lane-specific amount. The bits shifted out are used to round the quotient in one of six modes, and the rounded value is saturated into the lane's result range. Byte format reads eight 24-bit accumulators and gives eight unsigned bytes. Halfword format reads four 48-bit accumulators and gives four 16-bit values.

The shift amount can come from three places. It can be each lane's own field of a shift vector. It can be one selected field of that vector, broadcast to every lane. It can be an immediate, broadcast to every lane. A rounding-mode code chooses the rounding direction and whether the accumulator is read as signed or as a raw unsigned value. Combinations that are not allowed raise a flag and force the packed result to zero. The unit sits after the accumulator bank and drives the destination register write data.

Top module: `accrnd_readout`

## Requirements
- R1: With `halfFmt`=1, lane i (i = 0..3) reads `accBank[48i+47:48i]` and writes `result[16i+15:16i]`. Signed modes clamp the rounded value to -32768..32767.
- R2: With `halfFmt`=0, lane i (i = 0..7) reads `accBank[24i+23:24i]` and writes `result[8i+7:8i]`. The rounded value is clamped to 0..255.
- R3: `roundMode` codes are 0 nearest-away signed, 1 nearest-away unsigned, 2 nearest-even signed, 3 nearest-even unsigned, 4 toward-zero signed, 5 toward-zero unsigned. In halfword format, codes 0..5 are legal (`badMode`=0). In byte format, codes 1, 3 and 5 are legal.
- R4: Codes 6 and 7 in either format, and codes 0, 2 and 4 in byte format, set `badMode`=1 and drive `result` to zero.
- R5: Let s be the shift amount. The round bit is accumulator bit s-1, and sticky is the OR of the bits below it. Nearest-away adds one to the floor quotient when the round bit is set, except when the signed value is negative. In that case it adds one only if sticky is also set, so a negative tie moves away from zero.
- R6: Nearest-even adds one when the round bit is set and either sticky is set or the floor quotient is odd.
- R7: Toward-zero unsigned keeps the floor quotient. Toward-zero signed adds one to a negative floor quotient when any shifted-out bit is nonzero.
- R8: In unsigned modes, an accumulator whose top bit is set gives a lane result of zero when s is below the accumulator width.
- R9: In unsigned modes, when s is at or above the accumulator width, the lane result is the accumulator's top bit (0 or 1).
- R10: In signed modes, an amount above the accumulator width (48) acts as exactly 48.
- R11: An amount of zero applies no rounding, only the clamp.
- R12: `shiftSrc`=0 takes each lane's amount from its own field of `shiftVec` (8 bits per byte lane, 16 bits per halfword lane). `shiftSrc`=1 broadcasts the field chosen by `shiftLane` (halfword format uses `shiftLane[1:0]`). `shiftSrc`=2 or 3 broadcasts `shiftImm`, zero-extended.
- R13: Unsigned halfword results clamp to 0..65535.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| accBank | input | 192 | Accumulator bank: eight 24-bit or four 48-bit lanes |
| shiftVec | input | 64 | Packed per-lane shift amounts |
| shiftImm | input | IMM_W (8) | Broadcast immediate shift amount |
| shiftSrc | input | 2 | Shift source: 0 vector, 1 selected field, 2/3 immediate |
| shiftLane | input | 3 | Field index for broadcast-field source |
| halfFmt | input | 1 | 1 = four halfword lanes, 0 = eight byte lanes |
| roundMode | input | 3 | Rounding-mode code |
| result | output | 64 | Packed rounded and clamped lanes |
| badMode | output | 1 | Illegal mode/format combination |

## Verification
The bench builds the unit with the default 8-bit immediate. That width reaches shift amounts far beyond both accumulator widths, so the top-bit readout of the unsigned modes and the capped shift of the signed modes can both be driven from one port. A fixed table pins exact ties, odd and even quotients, negative ties and saturation in both formats. Pseudo-random lanes, half of them small sign-extended values, exercise every shift source against a reference model written from the arithmetic definitions.

// File: rtl/accrnd_pkg.sv
package accrnd_pkg;

  localparam int BYTE_LANES = 8;
  localparam int HALF_LANES = 4;
  localparam int BYTE_ACC_W = 24;
  localparam int HALF_ACC_W = 48;
  localparam int PACK_W     = 64;
  localparam int BANK_W     = BYTE_LANES * BYTE_ACC_W;
  localparam int BYTE_OUT_W = PACK_W / BYTE_LANES;
  localparam int HALF_OUT_W = PACK_W / HALF_LANES;
  localparam int LANE_SEL_W = $clog2(BYTE_LANES);
  localparam int HALF_SEL_W = $clog2(HALF_LANES);
  localparam int MODE_W     = 3;

  typedef enum logic [1:0] {
    RND_AWAY = 2'd0,
    RND_EVEN = 2'd1,
    RND_ZERO = 2'd2
  } rndKind_e;

  typedef struct packed {
    logic     legal;
    logic     signedArith;
    rndKind_e kind;
    logic     useVec;
    logic     useElem;
  } ctrlStrobe_t;

endpackage

// File: rtl/accrnd_ctrl.sv
module accrnd_ctrl
  import accrnd_pkg::*;
(
  input  logic              halfFmt,
  input  logic [MODE_W-1:0] roundMode,
  input  logic [1:0]        shiftSrc,
  output ctrlStrobe_t       strb
);

  localparam logic [MODE_W-1:0] LAST_CODE = MODE_W'(5);

  always_comb begin
    // odd codes are the unsigned variants; byte lanes only allow those
    strb.legal       = (roundMode <= LAST_CODE) && (halfFmt || roundMode[0]);
    strb.signedArith = ~roundMode[0];
    case (roundMode[2:1])
      2'b00:   strb.kind = RND_AWAY;
      2'b01:   strb.kind = RND_EVEN;
      default: strb.kind = RND_ZERO;
    endcase
    strb.useVec  = (shiftSrc == 2'd0);
    strb.useElem = (shiftSrc == 2'd1);
  end

endmodule

// File: rtl/accrnd_lane.sv
module accrnd_lane
  import accrnd_pkg::*;
#(
  parameter int ACC_W = 24,
  parameter int OUT_W = 8,
  parameter int AMT_W = 8
) (
  input  logic [ACC_W-1:0] acc,
  input  logic [AMT_W-1:0] amt,
  input  ctrlStrobe_t      strb,
  output logic [OUT_W-1:0] res
);

  localparam int SH_W  = $clog2(ACC_W + 1);
  localparam int EXT_W = ACC_W + 2;
  localparam logic [AMT_W-1:0] AMT_LIMIT = AMT_W'(ACC_W);
  localparam logic [ACC_W-1:0] ONE       = ACC_W'(1);
  localparam logic signed [EXT_W-1:0] S_MAX = EXT_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [EXT_W-1:0] S_MIN = -S_MAX - EXT_W'(1);
  localparam logic signed [EXT_W-1:0] U_MAX = EXT_W'((1 << OUT_W) - 1);

  logic                    wideAmt;
  logic [SH_W-1:0]         shEff;
  logic signed [ACC_W:0]   accExt;
  logic signed [ACC_W:0]   quot;
  logic [ACC_W-1:0]        bitSel;
  logic [ACC_W-1:0]        lowMask;
  logic                    roundBit;
  logic                    stickyBit;
  logic                    negVal;
  logic                    incr;
  logic signed [EXT_W-1:0] rnd;

  // shift, round-bit and sticky extraction
  always_comb begin
    wideAmt   = (amt >= AMT_LIMIT);
    shEff     = wideAmt ? SH_W'(ACC_W) : amt[SH_W-1:0];
    accExt    = strb.signedArith ? {acc[ACC_W-1], acc} : {1'b0, acc};
    quot      = accExt >>> shEff;
    bitSel    = (shEff == '0) ? '0 : (ONE << (shEff - SH_W'(1)));
    lowMask   = (shEff == '0) ? '0 : (bitSel - ONE);
    roundBit  = |(acc & bitSel);
    stickyBit = |(acc & lowMask);
    negVal    = strb.signedArith & acc[ACC_W-1];
  end

  // increment decision per rounding kind
  always_comb begin
    case (strb.kind)
      RND_AWAY: incr = roundBit & (~negVal | stickyBit);
      RND_EVEN: incr = roundBit & (stickyBit | quot[0]);
      default:  incr = negVal & (roundBit | stickyBit);
    endcase
    rnd = {quot[ACC_W], quot} + EXT_W'(incr);
  end

  // saturation to the lane range
  always_comb begin
    if (!strb.signedArith) begin
      if (wideAmt)
        res = OUT_W'(acc[ACC_W-1]);
      else if (acc[ACC_W-1])
        res = '0;
      else if (rnd > U_MAX)
        res = '1;
      else
        res = rnd[OUT_W-1:0];
    end else begin
      if (rnd > S_MAX)
        res = S_MAX[OUT_W-1:0];
      else if (rnd < S_MIN)
        res = S_MIN[OUT_W-1:0];
      else
        res = rnd[OUT_W-1:0];
    end
  end

endmodule

// File: rtl/accrnd_dp.sv
module accrnd_dp
  import accrnd_pkg::*;
#(
  parameter int IMM_W = 8
) (
  input  logic [BANK_W-1:0]     accBank,
  input  logic [PACK_W-1:0]     shiftVec,
  input  logic [IMM_W-1:0]      shiftImm,
  input  logic [LANE_SEL_W-1:0] shiftLane,
  input  logic                  halfFmt,
  input  ctrlStrobe_t           strb,
  output logic [PACK_W-1:0]     result
);

  localparam int BYTE_AMT_W = PACK_W / BYTE_LANES;
  localparam int HALF_AMT_W = PACK_W / HALF_LANES;

  logic [BYTE_AMT_W-1:0] elemByte;
  logic [HALF_AMT_W-1:0] elemHalf;
  logic [PACK_W-1:0]     bytePack;
  logic [PACK_W-1:0]     halfPack;

  always_comb begin
    elemByte = shiftVec[shiftLane*BYTE_AMT_W +: BYTE_AMT_W];
    elemHalf = shiftVec[shiftLane[HALF_SEL_W-1:0]*HALF_AMT_W +: HALF_AMT_W];
  end

  for (genvar g = 0; g < BYTE_LANES; g++) begin : g_byte
    logic [BYTE_AMT_W-1:0] laneAmt;
    logic [BYTE_OUT_W-1:0] laneRes;
    always_comb begin
      if (strb.useVec)       laneAmt = shiftVec[g*BYTE_AMT_W +: BYTE_AMT_W];
      else if (strb.useElem) laneAmt = elemByte;
      else                   laneAmt = BYTE_AMT_W'(shiftImm);
    end
    accrnd_lane #(
      .ACC_W(BYTE_ACC_W),
      .OUT_W(BYTE_OUT_W),
      .AMT_W(BYTE_AMT_W)
    ) u_lane (
      .acc (accBank[g*BYTE_ACC_W +: BYTE_ACC_W]),
      .amt (laneAmt),
      .strb(strb),
      .res (laneRes)
    );
    assign bytePack[g*BYTE_OUT_W +: BYTE_OUT_W] = laneRes;
  end

  for (genvar g = 0; g < HALF_LANES; g++) begin : g_half
    logic [HALF_AMT_W-1:0] laneAmt;
    logic [HALF_OUT_W-1:0] laneRes;
    always_comb begin
      if (strb.useVec)       laneAmt = shiftVec[g*HALF_AMT_W +: HALF_AMT_W];
      else if (strb.useElem) laneAmt = elemHalf;
      else                   laneAmt = HALF_AMT_W'(shiftImm);
    end
    accrnd_lane #(
      .ACC_W(HALF_ACC_W),
      .OUT_W(HALF_OUT_W),
      .AMT_W(HALF_AMT_W)
    ) u_lane (
      .acc (accBank[g*HALF_ACC_W +: HALF_ACC_W]),
      .amt (laneAmt),
      .strb(strb),
      .res (laneRes)
    );
    assign halfPack[g*HALF_OUT_W +: HALF_OUT_W] = laneRes;
  end

  always_comb begin
    if (!strb.legal)  result = '0;
    else if (halfFmt) result = halfPack;
    else              result = bytePack;
  end

endmodule

// File: rtl/accrnd_readout.sv
module accrnd_readout
  import accrnd_pkg::*;
#(
  parameter int IMM_W = 8
) (
  input  logic [BANK_W-1:0]     accBank,
  input  logic [PACK_W-1:0]     shiftVec,
  input  logic [IMM_W-1:0]      shiftImm,
  input  logic [1:0]            shiftSrc,
  input  logic [LANE_SEL_W-1:0] shiftLane,
  input  logic                  halfFmt,
  input  logic [MODE_W-1:0]     roundMode,
  output logic [PACK_W-1:0]     result,
  output logic                  badMode
);

  ctrlStrobe_t strb;

  accrnd_ctrl u_ctrl (
    .halfFmt  (halfFmt),
    .roundMode(roundMode),
    .shiftSrc (shiftSrc),
    .strb     (strb)
  );

  accrnd_dp #(.IMM_W(IMM_W)) u_dp (
    .accBank  (accBank),
    .shiftVec (shiftVec),
    .shiftImm (shiftImm),
    .shiftLane(shiftLane),
    .halfFmt  (halfFmt),
    .strb     (strb),
    .result   (result)
  );

  assign badMode = ~strb.legal;

endmodule

// File: rtl/accrnd_readout_chk.sv
module accrnd_readout_chk
  import accrnd_pkg::*;
#(
  parameter int IMM_W = 8
) (
  input logic [BANK_W-1:0]     accBank,
  input logic [PACK_W-1:0]     shiftVec,
  input logic [IMM_W-1:0]      shiftImm,
  input logic [1:0]            shiftSrc,
  input logic [LANE_SEL_W-1:0] shiftLane,
  input logic                  halfFmt,
  input logic [MODE_W-1:0]     roundMode,
  input logic [PACK_W-1:0]     result,
  input logic                  badMode
);

  localparam logic [IMM_W-1:0] IMM_HALF_W = IMM_W'(HALF_ACC_W);

  always_comb begin
    // R4
    if (badMode) illegal_zero_chk: assert (result == '0)
      else $error("illegal mode must give a zero result");
    // R4
    if (!halfFmt && !roundMode[0]) byte_signed_flag_chk: assert (badMode)
      else $error("signed code in byte format must be flagged");
    // R3
    if (halfFmt && roundMode <= MODE_W'(5)) half_legal_flag_chk: assert (!badMode)
      else $error("halfword codes 0..5 must be legal");

    for (int i = 0; i < HALF_LANES; i++) begin
      // R11
      if (halfFmt && !roundMode[0] && roundMode <= MODE_W'(4) && shiftSrc[1] &&
          shiftImm == '0 &&
          (accBank[i*HALF_ACC_W+15 +: HALF_ACC_W-15] == '0 ||
           accBank[i*HALF_ACC_W+15 +: HALF_ACC_W-15] == '1))
        zero_shift_pass_chk: assert (result[i*HALF_OUT_W +: HALF_OUT_W] ==
                                     accBank[i*HALF_ACC_W +: HALF_OUT_W])
          else $error("zero shift must pass an in-range value unchanged");
      // R8
      if (halfFmt && !badMode && roundMode[0] && shiftSrc[1] &&
          shiftImm < IMM_HALF_W && accBank[i*HALF_ACC_W + HALF_ACC_W-1])
        unsigned_neg_zero_chk: assert (result[i*HALF_OUT_W +: HALF_OUT_W] == '0)
          else $error("unsigned lane with top bit set must read zero");
      // R9
      if (halfFmt && !badMode && roundMode[0] && shiftSrc[1] && shiftImm >= IMM_HALF_W)
        wide_shift_top_chk: assert (result[i*HALF_OUT_W +: HALF_OUT_W] ==
                                    HALF_OUT_W'(accBank[i*HALF_ACC_W + HALF_ACC_W-1]))
          else $error("over-width unsigned shift must return the top bit");
    end
  end

endmodule

bind accrnd_readout accrnd_readout_chk #(.IMM_W(IMM_W)) i_chk (.*);

// File: tb/test_accrnd_readout.sv
module test_accrnd_readout;
  import accrnd_pkg::*;

  localparam int IMM_W = 8;
  localparam int ROWS  = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [BANK_W-1:0]     accBank   = '0;
  logic [PACK_W-1:0]     shiftVec  = '0;
  logic [IMM_W-1:0]      shiftImm  = '0;
  logic [1:0]            shiftSrc  = 2'd2;
  logic [LANE_SEL_W-1:0] shiftLane = '0;
  logic                  halfFmt   = 1'b1;
  logic [MODE_W-1:0]     roundMode = '0;
  logic [PACK_W-1:0]     result;
  logic                  badMode;

  accrnd_readout #(.IMM_W(IMM_W)) i_accrnd_readout (.*);

  int  errors = 0;
  int  checks = 0;
  bit  done   = 0;
  longint unsigned rs = 64'h9E37_79B9_7F4A_7C15;

  // {halfFmt, mode, acc[47:0], imm[7:0], expected lane[15:0], requirement}
  localparam logic [79:0] VEC [ROWS] = '{
    {1'b1, 3'd0, 48'h0000_0000_0018, 8'd4,  16'h0002, 4'd5},   // R5 positive tie
    {1'b1, 3'd0, 48'hFFFF_FFFF_FFE8, 8'd4,  16'hFFFE, 4'd5},   // R5 negative tie
    {1'b1, 3'd2, 48'h0000_0000_0028, 8'd4,  16'h0002, 4'd6},   // R6 tie to even
    {1'b1, 3'd2, 48'h0000_0000_0038, 8'd4,  16'h0004, 4'd6},   // R6 tie up to even
    {1'b1, 3'd2, 48'hFFFF_FFFF_FFD8, 8'd4,  16'hFFFE, 4'd6},   // R6 negative tie
    {1'b1, 3'd4, 48'hFFFF_FFFF_FFE8, 8'd4,  16'hFFFF, 4'd7},   // R7 signed truncation
    {1'b1, 3'd4, 48'h0000_7FFF_FFFF, 8'd0,  16'h7FFF, 4'd11},  // R11 clamp only
    {1'b1, 3'd0, 48'h8000_0000_0000, 8'd0,  16'h8000, 4'd1},   // R1 negative clamp
    {1'b1, 3'd1, 48'h8000_0000_0000, 8'd4,  16'h0000, 4'd8},   // R8
    {1'b1, 3'd1, 48'h8000_0000_0000, 8'd48, 16'h0001, 4'd9},   // R9
    {1'b1, 3'd3, 48'h0000_000F_FFF8, 8'd3,  16'hFFFF, 4'd13},  // R13
    {1'b1, 3'd5, 48'h0000_0001_2345, 8'd4,  16'h1234, 4'd7},   // R7 unsigned
    {1'b0, 3'd1, 48'h0000_0000_0188, 8'd1,  16'h00C4, 4'd2},   // R2
    {1'b0, 3'd3, 48'h0000_0000_000A, 8'd2,  16'h0002, 4'd6},   // R6 byte tie
    {1'b0, 3'd5, 48'h0000_000F_FFFF, 8'd4,  16'h00FF, 4'd2},   // R2 saturate
    {1'b0, 3'd1, 48'h0000_0080_0000, 8'd24, 16'h0001, 4'd9},   // R9 byte
    {1'b0, 3'd3, 48'h0000_0000_000E, 8'd2,  16'h0004, 4'd6},   // R6 byte up
    {1'b1, 3'd4, 48'hFFFF_FFFF_FFFF, 8'd60, 16'h0000, 4'd10}   // R10
  };

  function automatic longint unsigned nxt();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 7);
    rs = rs ^ (rs << 17);
    return rs;
  endfunction

  // arithmetic reference for one lane
  function automatic logic [15:0] ref_lane(input bit hf, input logic [2:0] md,
                                           input longint unsigned rawIn, input int sIn);
    int W = hf ? 48 : 24;
    int N = hf ? 16 : 8;
    int s = sIn;
    bit sgn = !md[0];
    longint unsigned raw = rawIn & ((longint'(1) << W) - 1);
    bit top = raw[W-1];
    longint val, q, rm, hv, hi, lo;
    if (!sgn) begin
      if (s >= W) return {15'd0, top};
      if (top) return 16'd0;
      val = longint'(raw);
    end else begin
      val = top ? longint'(raw) - (longint'(1) << W) : longint'(raw);
      if (s > W) s = W;
    end
    q = val;
    if (s > 0) begin
      q  = val >>> s;
      rm = val - (q <<< s);
      hv = longint'(1) << (s - 1);
      case (md[2:1])
        2'd0:    if (val >= 0 ? rm >= hv : rm > hv) q = q + 1;
        2'd1:    if (rm > hv || (rm == hv && q[0])) q = q + 1;
        default: if (sgn && val < 0 && rm != 0) q = q + 1;
      endcase
    end
    if (sgn) begin hi = 32767; lo = -32768; end
    else begin hi = (longint'(1) << N) - 1; lo = 0; end
    if (q > hi) q = hi;
    if (q < lo) q = lo;
    return q[15:0];
  endfunction

  function automatic logic [PACK_W-1:0] ref_pack(input bit hf, input logic [2:0] md,
      input logic [BANK_W-1:0] bank, input logic [1:0] src, input logic [2:0] ln,
      input logic [63:0] vec, input logic [7:0] imm);
    logic [PACK_W-1:0] r = '0;
    int a;
    if (md > 3'd5 || (!hf && !md[0])) return '0;
    if (hf) begin
      for (int i = 0; i < 4; i++) begin
        a = (src == 2'd0) ? int'(vec[16*i +: 16]) :
            (src == 2'd1) ? int'(vec[16*ln[1:0] +: 16]) : int'(imm);
        r[16*i +: 16] = ref_lane(1'b1, md, longint'(bank[48*i +: 48]), a);
      end
    end else begin
      for (int i = 0; i < 8; i++) begin
        logic [15:0] t;
        a = (src == 2'd0) ? int'(vec[8*i +: 8]) :
            (src == 2'd1) ? int'(vec[8*ln +: 8]) : int'(imm);
        t = ref_lane(1'b0, md, longint'(bank[24*i +: 24]), a);
        r[8*i +: 8] = t[7:0];
      end
    end
    return r;
  endfunction

  task automatic drive(input bit hf, input logic [2:0] md, input logic [BANK_W-1:0] bank,
                       input logic [1:0] src, input logic [2:0] ln,
                       input logic [63:0] vec, input logic [7:0] imm);
    @(negedge clk);
    halfFmt = hf; roundMode = md; accBank = bank; shiftSrc = src;
    shiftLane = ln; shiftVec = vec; shiftImm = imm;
    #3;
  endtask

  task automatic check(input string tag, input logic [63:0] expRes, input logic expBad);
    checks++;
    if (result !== expRes || badMode !== expBad) begin
      errors++;
      $display("FAIL %s: result=%h bad=%b expected result=%h bad=%b",
               tag, result, badMode, expRes, expBad);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk); #3;
    check("R1 reset idle state", 64'd0, 1'b0);

    // table of single-lane cases, replicated across lanes, immediate shift
    for (int i = 0; i < ROWS; i++) begin
      logic [79:0] row = VEC[i];
      logic [BANK_W-1:0] bank;
      logic [63:0] ex;
      bank = row[79] ? {4{row[75:28]}} : {8{row[51:28]}};
      ex   = row[79] ? {4{row[19:4]}} : {8{row[11:4]}};
      drive(row[79], row[78:76], bank, 2'd2, 3'd0, 64'd0, row[27:20]);
      check($sformatf("R%0d table row %0d", row[3:0], i), ex, 1'b0);
    end

    // R4 illegal combinations
    for (int m = 0; m < 8; m++) begin
      drive(1'b0, 3'(m), {8{24'h00_1234}}, 2'd2, 3'd0, 64'd0, 8'd2);
      if (m[0] == 1'b0 || m > 5) check("R4 byte illegal code", 64'd0, 1'b1);
      else check("R3 byte legal code", ref_pack(1'b0, 3'(m), accBank, 2'd2, 3'd0, 64'd0, 8'd2), 1'b0);
    end
    for (int m = 0; m < 8; m++) begin
      drive(1'b1, 3'(m), {4{48'h0000_0001_2345}}, 2'd2, 3'd0, 64'd0, 8'd4);
      if (m > 5) check("R4 half illegal code", 64'd0, 1'b1);
      else check("R3 half legal code", ref_pack(1'b1, 3'(m), accBank, 2'd2, 3'd0, 64'd0, 8'd4), 1'b0);
    end

    // R12 shift sources, hand-computed
    drive(1'b1, 3'd5, {4{48'h0000_0000_FF00}}, 2'd0, 3'd0,
          {16'd12, 16'd0, 16'd4, 16'd8}, 8'd0);
    check("R12 per-lane vector", 64'h000F_FF00_0FF0_00FF, 1'b0);
    drive(1'b1, 3'd5, {4{48'h0000_0000_FF00}}, 2'd1, 3'd6,
          {16'd12, 16'd0, 16'd4, 16'd8}, 8'd0);
    check("R12 broadcast field half", 64'hFF00_FF00_FF00_FF00, 1'b0);
    drive(1'b1, 3'd5, {4{48'h0000_0000_FF00}}, 2'd3, 3'd0,
          {16'd12, 16'd0, 16'd4, 16'd8}, 8'd4);
    check("R12 broadcast immediate", 64'h0FF0_0FF0_0FF0_0FF0, 1'b0);
    drive(1'b0, 3'd5, {8{24'h00_0F00}}, 2'd1, 3'd5,
          64'h0000_0400_0000_0000, 8'd0);
    check("R12 broadcast field byte", 64'hF0F0_F0F0_F0F0_F0F0, 1'b0);

    // R12 pseudo-random against the reference
    for (int k = 0; k < 400; k++) begin
      longint unsigned r = nxt();
      bit hf = r[0];
      logic [2:0] md;
      logic [1:0] src = 2'((r >> 12) % 3);
      logic [2:0] ln  = 3'(r >> 16);
      logic [BANK_W-1:0] bank = '0;
      logic [63:0] vec = '0;
      logic [7:0] imm;
      md = hf ? 3'((r >> 8) % 6) : 3'(((r >> 8) % 3) * 2 + 1);
      for (int i = 0; i < 8; i++) begin
        longint unsigned v = nxt();
        if (hf && i < 4) begin
          bank[48*i +: 48] = v[0] ? {{28{v[20]}}, v[20:1]} : v[48:1];
          vec[16*i +: 16]  = 16'((v >> 50) % 56);
        end else if (!hf) begin
          bank[24*i +: 24] = v[0] ? {{12{v[12]}}, v[12:1]} : v[24:1];
          vec[8*i +: 8]    = 8'((v >> 50) % 30);
        end
      end
      imm = hf ? 8'((r >> 20) % 56) : 8'((r >> 20) % 30);
      if ((r >> 30) % 7 == 0) imm = 8'd200;
      drive(hf, md, bank, src, ln, vec, imm);
      check("R12 random vector", ref_pack(hf, md, bank, src, ln, vec, imm), 1'b0);
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule